// File: doc/BRIEF.md
# Integer ALU with Condition Flags and Branch Resolution

This block is the arithmetic and logic unit of a 64-bit integer datapath, together with the flag state that conditional branches test. Each cycle it combines two operands under a 3-bit operation select, giving a result and the Negative, Zero, Overflow and Carry values that result would produce. A flag register inside the block holds the flags. It loads new values on a clock edge only when the set-flags enable is high and the operation is one of the kinds that has a flag-setting form: add, subtract or AND.

Two branch decisions come out of the block every cycle. The first evaluates a 4-bit condition code against the stored flags: equal, not equal, and the four signed orderings. The second is a compare-and-branch test, which asks whether a register value is zero or nonzero. Both are purely combinational, so the branch logic can use them in the cycle the condition is presented. Multiply, divide and floating point are not part of the block.

Top module: `alu_flag_unit`

## Requirements
- R1: `result` is a function of `op_a`, `op_b` and `alu_op` alone, with this encoding: 0 gives `op_a + op_b`, 1 gives `op_a - op_b`, 2 gives AND, 3 gives OR, 4 gives XOR, 5 shifts `op_a` left and 6 shifts it right (both logical, zeros shifted in, shift amount = the low log2(WIDTH) bits of `op_b`), and 7 gives zero.
- R2: `res_flags` is packed as {N, Z, V, C} in bits 3..0. N equals the result's top bit and Z is 1 exactly when the result is all zeros. For OR, XOR, shifts and code 7, V and C are 0.
- R3: For add, C is the carry out of the top bit and V is 1 when both operands have the same sign and the result's sign differs. For subtract, computed as `op_a + ~op_b + 1`, C is 1 when no borrow occurs (op_a >= op_b unsigned), and V is 1 when the operand signs differ and the result's sign differs from `op_a`.
- R4: For AND, V and C are both 0 and N and Z follow the result.
- R5: On a rising clock edge `flags_q` loads `res_flags` when `set_flags` is 1 and `alu_op` is 0, 1 or 2. With `set_flags` low, or with any other operation, `flags_q` keeps its value.
- R6: `cond_taken` evaluates `cond_code` against `flags_q`: 0x0 taken when Z, 0x1 when not Z, 0xA when N equals V, 0xB when N differs from V, 0xC when not Z and N equals V, 0xD when Z or N differs from V.
- R7: Any `cond_code` other than 0x0, 0x1, 0xA, 0xB, 0xC or 0xD gives `cond_taken` = 0, whatever the flags are.
- R8: `reg_taken` is 1 when `test_nz` = 0 and `test_val` is zero, or when `test_nz` = 1 and `test_val` is nonzero. Otherwise it is 0.
- R9: An active-low asynchronous reset `rst_n` clears `flags_q` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand, or shift amount in its low bits |
| alu_op | input | 3 | Operation select (encoding in R1) |
| set_flags | input | 1 | Flag write enable for add, subtract and AND |
| cond_code | input | 4 | Condition code tested against stored flags |
| test_val | input | WIDTH | Register value for the zero/nonzero test |
| test_nz | input | 1 | 0 = take when zero, 1 = take when nonzero |
| result | output | WIDTH | Operation result |
| res_flags | output | 4 | {N,Z,V,C} of the current result |
| flags_q | output | 4 | Stored {N,Z,V,C} |
| cond_taken | output | 1 | Flag-conditional branch decision |
| reg_taken | output | 1 | Compare-and-branch decision |

## Verification
The bench builds an 8-bit copy of the unit and sweeps operand pairs over every operation. The pairs include the signed and unsigned wrap points 0x7F/0x80, 0xFF + 1 and 0x80 + 0x80. A design with the subtract carry inverted, so that it reports a borrow instead of no-borrow, or with overflow taken from the wrong operand sign, fails here. Each of a set of flag states is loaded and then all sixteen condition codes are walked. This catches a swapped GE/LT decode, and it catches a GT or LE that ignores Z. It also catches an undefined code that is taken. After every load, a flag-setting request on OR and a plain add with the enable low must leave the stored flags untouched. A design that writes flags on any operation would change them at that point.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

    typedef enum logic [2:0] {
        ALU_ADD  = 3'd0,
        ALU_SUB  = 3'd1,
        ALU_AND  = 3'd2,
        ALU_OR   = 3'd3,
        ALU_XOR  = 3'd4,
        ALU_SHL  = 3'd5,
        ALU_SHR  = 3'd6,
        ALU_NONE = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic neg;
        logic zero;
        logic ovf;
        logic cry;
    } flags_t;

    localparam logic [3:0] CC_EQ = 4'h0;
    localparam logic [3:0] CC_NE = 4'h1;
    localparam logic [3:0] CC_GE = 4'hA;
    localparam logic [3:0] CC_LT = 4'hB;
    localparam logic [3:0] CC_GT = 4'hC;
    localparam logic [3:0] CC_LE = 4'hD;

    function automatic logic op_has_flag_form(input alu_op_e op);
        return (op == ALU_ADD) || (op == ALU_SUB) || (op == ALU_AND);
    endfunction

endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
    parameter int WIDTH = 64
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             subtract,
    output logic [WIDTH-1:0] sum,
    output logic             carry,
    output logic             ovf
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   wide;

    always_comb begin
        b_eff = subtract ? ~b : b;
        wide  = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, subtract};
        sum   = wide[WIDTH-1:0];
        carry = wide[WIDTH];
        // Signed overflow: same-sign effective operands, differing result sign
        ovf   = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
    end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
    parameter int WIDTH = 64
) (
    input  logic [WIDTH-1:0]         a,
    input  logic [$clog2(WIDTH)-1:0] amt,
    input  logic                     left,
    output logic [WIDTH-1:0]         y
);
    localparam int STAGES = $clog2(WIDTH);

    logic [WIDTH-1:0] stage [0:STAGES];

    assign stage[0] = a;

    // One logarithmic stage per bit of the shift amount
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        localparam int STEP = 1 << s;
        assign stage[s+1] = !amt[s] ? stage[s]
                          : (left ? (stage[s] << STEP) : (stage[s] >> STEP));
    end

    assign y = stage[STAGES];
endmodule

// File: rtl/alu_cond_eval.sv
module alu_cond_eval
    import alu_flag_pkg::*;
(
    input  flags_t     flags,
    input  logic [3:0] cc,
    output logic       taken
);
    logic signs_agree;

    always_comb begin
        signs_agree = (flags.neg == flags.ovf);
        unique case (cc)
            CC_EQ:   taken = flags.zero;
            CC_NE:   taken = !flags.zero;
            CC_GE:   taken = signs_agree;
            CC_LT:   taken = !signs_agree;
            CC_GT:   taken = !flags.zero && signs_agree;
            CC_LE:   taken = flags.zero || !signs_agree;
            default: taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu_reg_test.sv
module alu_reg_test #(
    parameter int WIDTH = 64
) (
    input  logic [WIDTH-1:0] val,
    input  logic             want_nonzero,
    output logic             taken
);
    logic any_set;

    always_comb begin
        any_set = |val;
        taken   = want_nonzero ? any_set : !any_set;
    end
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
    import alu_flag_pkg::*;
#(
    parameter int WIDTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [2:0]       alu_op,
    input  logic             set_flags,
    input  logic [3:0]       cond_code,
    input  logic [WIDTH-1:0] test_val,
    input  logic             test_nz,
    output logic [WIDTH-1:0] result,
    output logic [3:0]       res_flags,
    output logic [3:0]       flags_q,
    output logic             cond_taken,
    output logic             reg_taken
);
    localparam int MSB = WIDTH - 1;
    localparam int SHW = $clog2(WIDTH);

    typedef struct packed {
        flags_t flags;
    } state_t;

    alu_op_e          op;
    logic [WIDTH-1:0] add_sum;
    logic             add_cry;
    logic             add_ovf;
    logic [WIDTH-1:0] shf_out;
    flags_t           cur_flags;
    state_t           st_d;
    state_t           st_q;

    assign op = alu_op_e'(alu_op);

    alu_adder #(.WIDTH(WIDTH)) u_add (
        .a        (op_a),
        .b        (op_b),
        .subtract (op == ALU_SUB),
        .sum      (add_sum),
        .carry    (add_cry),
        .ovf      (add_ovf)
    );

    alu_shifter #(.WIDTH(WIDTH)) u_shf (
        .a    (op_a),
        .amt  (op_b[SHW-1:0]),
        .left (op == ALU_SHL),
        .y    (shf_out)
    );

    alu_cond_eval u_cond (
        .flags (st_q.flags),
        .cc    (cond_code),
        .taken (cond_taken)
    );

    alu_reg_test #(.WIDTH(WIDTH)) u_ztest (
        .val          (test_val),
        .want_nonzero (test_nz),
        .taken        (reg_taken)
    );

    // Result select and the flags that result would produce
    always_comb begin
        unique case (op)
            ALU_ADD, ALU_SUB: result = add_sum;
            ALU_AND:          result = op_a & op_b;
            ALU_OR:           result = op_a | op_b;
            ALU_XOR:          result = op_a ^ op_b;
            ALU_SHL, ALU_SHR: result = shf_out;
            default:          result = '0;
        endcase
        cur_flags.neg  = result[MSB];
        cur_flags.zero = (result == '0);
        if (op == ALU_ADD || op == ALU_SUB) begin
            cur_flags.ovf = add_ovf;
            cur_flags.cry = add_cry;
        end else begin
            cur_flags.ovf = 1'b0;
            cur_flags.cry = 1'b0;
        end
    end

    // Next state
    always_comb begin
        st_d = st_q;
        if (set_flags && op_has_flag_form(op)) begin
            st_d.flags = cur_flags;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_flags = cur_flags;
    assign flags_q   = st_q.flags;

endmodule

// File: rtl/alu_flag_unit_chk.sv
module alu_flag_unit_chk #(
    parameter int WIDTH = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       alu_op,
    input logic             set_flags,
    input logic [3:0]       cond_code,
    input logic [WIDTH-1:0] test_val,
    input logic             test_nz,
    input logic [WIDTH-1:0] result,
    input logic [3:0]       res_flags,
    input logic [3:0]       flags_q,
    input logic             cond_taken,
    input logic             reg_taken
);
    logic writes;
    assign writes = set_flags && (alu_op <= 3'd2);

    p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
        writes |=> (flags_q == $past(res_flags)));

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !writes |=> $stable(flags_q));

    p_zero_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        res_flags[2] == (result == '0));

    p_and_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_op == 3'd2) |-> (res_flags[1:0] == 2'b00));

    p_undef_cc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(cond_code inside {4'h0, 4'h1, 4'hA, 4'hB, 4'hC, 4'hD}) |-> !cond_taken);

    p_eq_ne_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_code == 4'h0) |-> (cond_taken == flags_q[2]));

    p_reg_test_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_taken == (test_nz ? (test_val != '0) : (test_val == '0)));

endmodule

bind alu_flag_unit alu_flag_unit_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/sim_alu_flag_unit.sv
`timescale 1ns/1ps
module sim_alu_flag_unit;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] op_a, op_b, test_val, result;
    logic [2:0]   alu_op;
    logic         set_flags, test_nz, cond_taken, reg_taken;
    logic [3:0]   cond_code, res_flags, flags_q;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 0;
    logic [3:0] model_flags;

    always #10 clk = ~clk;

    alu_flag_unit #(.WIDTH(W)) u0 (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .alu_op(alu_op),
        .set_flags(set_flags), .cond_code(cond_code), .test_val(test_val),
        .test_nz(test_nz), .result(result), .res_flags(res_flags),
        .flags_q(flags_q), .cond_taken(cond_taken), .reg_taken(reg_taken)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] exp_res(input int op, input int a, input int b);
        case (op)
            0: return W'(a + b);
            1: return W'(a - b);
            2: return W'(a & b);
            3: return W'(a | b);
            4: return W'(a ^ b);
            5: return W'(a << (b % W));
            6: return W'(a >> (b % W));
            default: return '0;
        endcase
    endfunction

    function automatic int sgn(input int x);
        return (x >= 128) ? x - 256 : x;
    endfunction

    function automatic logic [3:0] exp_flags(input int op, input int a, input int b);
        logic [W-1:0] r;
        logic v, c;
        int s;
        r = exp_res(op, a, b);
        v = 0; c = 0;
        if (op == 0) begin
            c = (a + b) > 255;
            s = sgn(a) + sgn(b);
            v = (s > 127) || (s < -128);
        end else if (op == 1) begin
            c = (a >= b);
            s = sgn(a) - sgn(b);
            v = (s > 127) || (s < -128);
        end
        return {r[W-1], (r == 0), v, c};
    endfunction

    function automatic logic exp_cond(input int cc, input logic [3:0] f);
        case (cc)
            0:  return f[2];
            1:  return !f[2];
            10: return f[3] == f[1];
            11: return f[3] != f[1];
            12: return !f[2] && (f[3] == f[1]);
            13: return f[2] || (f[3] != f[1]);
            default: return 1'b0;
        endcase
    endfunction

    function automatic int pick_b(input int j);
        case (j)
            24: return 255;
            25: return 128;
            26: return 127;
            27: return 1;
            default: return j * 11;
        endcase
    endfunction

    task automatic sweep_conds(input string tag);
        for (int cc = 0; cc < 16; cc++) begin
            cond_code = 4'(cc);
            #1;
            if (exp_cond(cc, model_flags) || (cc inside {0, 1, 10, 11, 12, 13}))
                chk({"R6 cond ", tag}, cond_taken, exp_cond(cc, model_flags));
            else
                chk({"R7 undefined cond ", tag}, cond_taken, 0);
        end
    endtask

    task automatic flag_case(input int op, input int a, input int b);
        @(negedge clk);
        alu_op = 3'(op); op_a = W'(a); op_b = W'(b); set_flags = 1'b1;
        @(posedge clk);
        #1;
        model_flags = exp_flags(op, a, b);
        chk("R5 flags load", flags_q, model_flags);
        sweep_conds("after load");
        // non-writing requests: OR with enable, add without enable
        @(negedge clk);
        alu_op = 3'd3; op_a = 8'h80; op_b = 8'h00; set_flags = 1'b1;
        @(negedge clk);
        alu_op = 3'd0; op_a = 8'hFF; op_b = 8'h01; set_flags = 1'b0;
        @(negedge clk);
        chk("R5 flags hold", flags_q, model_flags);
        sweep_conds("after hold");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; op_a = '0; op_b = '0; alu_op = '0; set_flags = 1'b0;
        cond_code = '0; test_val = '0; test_nz = 1'b0;
        model_flags = 4'h0;
        repeat (3) @(negedge clk);
        chk("R9 reset flags", flags_q, 0);
        sweep_conds("reset");
        rst_n = 1'b1;

        // R1..R4 sweep of every operation
        for (int op = 0; op < 8; op++) begin
            for (int a = 0; a < 256; a += 3) begin
                for (int j = 0; j < 28; j++) begin
                    int b;
                    b = pick_b(j);
                    alu_op = 3'(op); op_a = W'(a); op_b = W'(b);
                    #1;
                    chk("R1 result", result, exp_res(op, a, b));
                    if (op == 2)
                        chk("R4 and flags", res_flags, exp_flags(op, a, b));
                    else if (op <= 1)
                        chk("R3 arith flags", res_flags, exp_flags(op, a, b));
                    else
                        chk("R2 flags", res_flags, exp_flags(op, a, b));
                end
            end
        end

        // R5, R6, R7 on a set of flag states
        flag_case(1, 5, 5);
        flag_case(1, 3, 5);
        flag_case(1, 8'h80, 1);
        flag_case(0, 8'h7F, 1);
        flag_case(0, 8'hFF, 1);
        flag_case(2, 8'hF0, 8'h80);
        flag_case(2, 8'h0F, 8'hF0);
        flag_case(1, 5, 3);
        flag_case(1, 8'h7F, 8'hFF);
        flag_case(0, 8'h80, 8'h80);
        flag_case(1, 8'hFE, 8'h02);

        // R8 register zero/nonzero test
        for (int v = 0; v < 256; v++) begin
            for (int nz = 0; nz < 2; nz++) begin
                test_val = W'(v); test_nz = nz[0];
                #1;
                chk("R8 reg test", reg_taken, nz ? (v != 0) : (v == 0));
            end
        end

        // R9 asynchronous reset clears loaded flags
        flag_case(1, 3, 5);
        #3 rst_n = 1'b0;
        #1;
        chk("R9 async reset", flags_q, 0);
        rst_n = 1'b1;

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule